// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block sits between a synchronous host and an external asynchronous static RAM of 2M x 8. The host makes one request at a time. Each request carries a read/write flag, a 21-bit address and, for a write, one data byte. The controller turns the request into a read cycle or a write cycle on the memory pins. It counts whole clock cycles for every timing minimum of the memory. Each count comes from the memory's nanosecond figures and a clock-period parameter: the figure is divided by the period, rounded up, and never set below one cycle.

The memory is selected only while its low-true enable is low and its high-true enable is high. A read holds write enable high and output enable low. A write pulses write enable low and keeps output enable high for the whole operation. The controller turns on its own data drivers only after the memory can no longer be driving the bus. While no request is in progress, the chip is deselected so that it draws standby current. Read data is registered at the end of the access time and returned with a single-cycle valid pulse. The host ready signal stays low from the accepted request until the memory cycle time has passed.

Top module: `sram_ctrl`

## Requirements
- R1: After reset and whenever `ready_o` is high, the memory is deselected: `mem_ce1_no`=1, `mem_ce2_o`=0, `mem_we_no`=1, `mem_oe_no`=1, `mem_dq_oe_o`=0.
- R2: A read drives the chip selected with `mem_we_no`=1 and `mem_oe_no`=0. The read returns the stored byte on `rdata_o` with `rvalid_o` high, exactly ceil(tAA/CLK_NS) cycles after the accepting clock edge.
- R3: In a write, `mem_we_no` is low for at least max(ceil(tWP/CLK_NS), ceil(tDW/CLK_NS)) cycles. The write ends no earlier than tAW after the address was applied. Write data is driven for the whole low pulse and for one cycle after `mem_we_no` rises.
- R4: The address changes only when a request is accepted, and never while `mem_we_no` is low. Address and write data are stable for the whole write pulse.
- R5: Output enable stays high for the whole write operation. The controller drives `mem_dq_oe_o` only after output enable has been high for ceil(max(tOHZ,tCHZ)/CLK_NS) cycles, so the two sides never drive the bus together.
- R6: `ready_o` stays low for at least ceil(tRC/CLK_NS) cycles after an accepted read, and at least ceil(tWC/CLK_NS) cycles after an accepted write. Any request presented while `ready_o` is low is ignored and has no effect on the memory.
- R7: `SPEED_GRADE`=0 selects tAA=tRC=tWC=55, tWP=30, tAW=40, tDW=25 and bus release 30 ns. `SPEED_GRADE`=1 selects 70, 35, 50, 30 and 35 ns. Each figure becomes cycles by rounding up the division by `CLK_NS`, with a minimum of 1.
- R8: A write followed at once by a read of the same address returns the new byte. A read followed at once by a write completes without bus contention, and a later read returns the new byte.
- R9: `rvalid_o` pulses for one cycle, once per accepted read and never for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request; accepted on a clock edge where `ready_o` is high |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 21 | Byte address |
| req_wdata_i | input | 8 | Write data |
| ready_o | output | 1 | Controller can accept a request |
| rvalid_o | output | 1 | One-cycle pulse marking valid read data |
| rdata_o | output | 8 | Read data |
| mem_addr_o | output | 21 | Memory address bus |
| mem_ce1_no | output | 1 | Memory chip enable, active low |
| mem_ce2_o | output | 1 | Memory chip enable, active high |
| mem_we_no | output | 1 | Memory write enable, active low |
| mem_oe_no | output | 1 | Memory output enable, active low |
| mem_dq_o | output | 8 | Data to the memory |
| mem_dq_i | input | 8 | Data from the memory |
| mem_dq_oe_o | output | 1 | Enable for the controller's data drivers |

## Verification
The hardest case to reach is a write accepted in the cycle right after a read finishes. The memory may still be driving the bus at that point, so the turnaround wait decides whether contention happens. The bench reaches this case by chaining requests with no idle cycle: each new request is presented on the same cycle that ready is first seen high. A behavioural memory model keeps driving the bus for the full release time after a read. It flags any overlap with the controller's drivers, and it times every write edge against the memory minima. A request is also presented in the middle of a busy read and withdrawn once ready rises, so that a leaked write would show up when that location is read back.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_WSETUP, ST_WPULSE, ST_WHOLD, ST_WAIT
  } state_e;

  typedef enum int {
    TP_AA, TP_RC, TP_WC, TP_WP, TP_AW, TP_DW, TP_TURN
  } tparam_e;

  typedef struct packed {
    logic ce1_n;
    logic ce2;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } bus_ctl_t;

  // memory minima in ns, grade 0 = fast, otherwise slow
  function automatic int unsigned ns_of(tparam_e p, int unsigned grade);
    int unsigned v;
    case (p)
      TP_AA:   v = (grade == 0) ? 55 : 70;
      TP_RC:   v = (grade == 0) ? 55 : 70;
      TP_WC:   v = (grade == 0) ? 55 : 70;
      TP_WP:   v = (grade == 0) ? 30 : 35;
      TP_AW:   v = (grade == 0) ? 40 : 50;
      TP_DW:   v = (grade == 0) ? 25 : 30;
      TP_TURN: v = (grade == 0) ? 30 : 35; // worst of OE and CE release
      default: v = 1;
    endcase
    return v;
  endfunction

  function automatic int unsigned to_cycles(int unsigned ns, int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic bus_ctl_t decode(state_e s);
    bus_ctl_t c;
    c.ce1_n = 1'b0;
    c.ce2   = 1'b1;
    c.we_n  = 1'b1;
    c.oe_n  = 1'b1;
    c.dq_oe = 1'b0;
    case (s)
      ST_IDLE: begin
        c.ce1_n = 1'b1;
        c.ce2   = 1'b0;
      end
      ST_RD:     c.oe_n = 1'b0;
      ST_WPULSE: begin
        c.we_n  = 1'b0;
        c.dq_oe = 1'b1;
      end
      ST_WHOLD:  c.dq_oe = 1'b1;
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sram_timer.sv
`timescale 1ns/1ps
module sram_timer #(
  parameter int unsigned W       = 4,
  parameter int unsigned MAX     = 7,
  parameter int unsigned RST_VAL = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= W'(RST_VAL);
    else if (clr_i)            cnt_q <= '0;
    else if (cnt_q < W'(MAX))  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // saturating counter never passes its limit
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= W'(MAX));
endmodule

// File: rtl/sram_fsm.sv
`timescale 1ns/1ps
module sram_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned T_AA   = 7,
  parameter int unsigned T_RC   = 7,
  parameter int unsigned T_WC   = 7,
  parameter int unsigned T_PW   = 4,
  parameter int unsigned T_AW   = 5,
  parameter int unsigned T_TURN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] elapsed_i,
  input  logic [CNT_W-1:0] phase_i,
  input  logic [CNT_W-1:0] quiet_i,
  output logic             accept_o,
  output logic             capture_o,
  output logic             phase_clr_o,
  output logic             ready_o,
  output bus_ctl_t         ctl_o
);
  localparam logic [CNT_W-1:0] L_AA   = CNT_W'(T_AA - 1);
  localparam logic [CNT_W-1:0] L_RC   = CNT_W'(T_RC - 1);
  localparam logic [CNT_W-1:0] L_WC   = CNT_W'(T_WC - 1);
  localparam logic [CNT_W-1:0] L_PW   = CNT_W'(T_PW - 1);
  localparam logic [CNT_W-1:0] L_AW   = CNT_W'(T_AW - 1);
  localparam logic [CNT_W-1:0] L_TURN = CNT_W'(T_TURN - 1);
  localparam logic [CNT_W-1:0] L_MIN  = (L_RC < L_WC) ? L_RC : L_WC;

  state_e   st_q, st_d;
  logic     op_we_q;
  bus_ctl_t ctl_q;

  assign ready_o  = (st_q == ST_IDLE);
  assign accept_o = ready_o && req_i;

  always_comb begin
    st_d        = st_q;
    capture_o   = 1'b0;
    phase_clr_o = 1'b0;
    case (st_q)
      ST_IDLE:   if (req_i) st_d = we_i ? ST_WSETUP : ST_RD;
      ST_RD: if (elapsed_i >= L_AA) begin
        capture_o = 1'b1;
        st_d      = (elapsed_i >= L_RC) ? ST_IDLE : ST_WAIT;
      end
      // wait until the memory has released the bus
      ST_WSETUP: if (quiet_i >= L_TURN) begin
        phase_clr_o = 1'b1;
        st_d        = ST_WPULSE;
      end
      ST_WPULSE: if (phase_i >= L_PW && elapsed_i >= L_AW) st_d = ST_WHOLD;
      ST_WHOLD:  st_d = (elapsed_i >= L_WC) ? ST_IDLE : ST_WAIT;
      ST_WAIT:   if (elapsed_i >= (op_we_q ? L_WC : L_RC)) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      op_we_q <= 1'b0;
      ctl_q   <= decode(ST_IDLE);
    end else begin
      st_q  <= st_d;
      ctl_q <= decode(st_d); // registered pins, no decode glitches
      if (accept_o) op_we_q <= we_i;
    end
  end

  assign ctl_o = ctl_q;

  // R1
  idle_deselect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (ctl_q.ce1_n && !ctl_q.ce2 && ctl_q.we_n && ctl_q.oe_n && !ctl_q.dq_oe));
  // R2
  read_ctl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_q.oe_n |-> (ctl_q.we_n && !ctl_q.ce1_n && ctl_q.ce2));
  // R3
  we_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_q.we_n |-> ctl_q.dq_oe);
  // R6
  min_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> ($past(elapsed_i) >= L_MIN));
endmodule

// File: rtl/sram_datapath.sv
`timescale 1ns/1ps
module sram_datapath #(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rvalid_q;

  // address held between requests to avoid needless toggling
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= capture_i;
      if (capture_i) rdata_q <= mem_dq_i;
    end
  end

  assign mem_addr_o = addr_q;
  assign mem_dq_o   = wdata_q;
  assign rdata_o    = rdata_q;
  assign rvalid_o   = rvalid_q;

  // R9
  rvalid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_q |=> !rvalid_q);
endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 21,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CLK_NS      = 8,
  parameter int unsigned SPEED_GRADE = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              ready_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce1_no,
  output logic              mem_ce2_o,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_dq_oe_o
);
  localparam int unsigned T_AA   = to_cycles(ns_of(TP_AA,   SPEED_GRADE), CLK_NS);
  localparam int unsigned T_RC   = to_cycles(ns_of(TP_RC,   SPEED_GRADE), CLK_NS);
  localparam int unsigned T_WC   = to_cycles(ns_of(TP_WC,   SPEED_GRADE), CLK_NS);
  localparam int unsigned T_WP   = to_cycles(ns_of(TP_WP,   SPEED_GRADE), CLK_NS);
  localparam int unsigned T_AW   = to_cycles(ns_of(TP_AW,   SPEED_GRADE), CLK_NS);
  localparam int unsigned T_DW   = to_cycles(ns_of(TP_DW,   SPEED_GRADE), CLK_NS);
  localparam int unsigned T_TURN = to_cycles(ns_of(TP_TURN, SPEED_GRADE), CLK_NS);
  localparam int unsigned T_PW   = max2(T_WP, T_DW);
  localparam int unsigned T_MAX  = max2(max2(max2(T_AA, T_RC), max2(T_WC, T_AW)),
                                        max2(T_PW, T_TURN));
  localparam int unsigned CNT_W  = $clog2(T_MAX + 2);

  logic             accept, capture, phase_clr;
  logic [CNT_W-1:0] elapsed, phase, quiet;
  bus_ctl_t         ctl;

  // cycles since the accepted request
  sram_timer #(.W(CNT_W), .MAX(T_MAX), .RST_VAL(T_MAX)) u_elapsed (
    .clk_i, .rst_ni, .clr_i(accept), .cnt_o(elapsed));

  // length of the write-enable pulse
  sram_timer #(.W(CNT_W), .MAX(T_PW), .RST_VAL(0)) u_phase (
    .clk_i, .rst_ni, .clr_i(phase_clr), .cnt_o(phase));

  // cycles since output enable was last low (bus release)
  sram_timer #(.W(CNT_W), .MAX(T_TURN), .RST_VAL(T_TURN)) u_quiet (
    .clk_i, .rst_ni, .clr_i(!ctl.oe_n), .cnt_o(quiet));

  sram_fsm #(
    .CNT_W(CNT_W), .T_AA(T_AA), .T_RC(T_RC), .T_WC(T_WC),
    .T_PW(T_PW), .T_AW(T_AW), .T_TURN(T_TURN)
  ) u_fsm (
    .clk_i, .rst_ni,
    .req_i,
    .we_i        (req_we_i),
    .elapsed_i   (elapsed),
    .phase_i     (phase),
    .quiet_i     (quiet),
    .accept_o    (accept),
    .capture_o   (capture),
    .phase_clr_o (phase_clr),
    .ready_o,
    .ctl_o       (ctl)
  );

  sram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk_i, .rst_ni,
    .accept_i   (accept),
    .capture_i  (capture),
    .addr_i     (req_addr_i),
    .wdata_i    (req_wdata_i),
    .mem_dq_i,
    .mem_addr_o,
    .mem_dq_o,
    .rdata_o,
    .rvalid_o
  );

  assign mem_ce1_no  = ctl.ce1_n;
  assign mem_ce2_o   = ctl.ce2;
  assign mem_we_no   = ctl.we_n;
  assign mem_oe_no   = ctl.oe_n;
  assign mem_dq_oe_o = ctl.dq_oe;

  // R4
  wr_addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_no && $past(!mem_we_no)) |-> ($stable(mem_addr_o) && $stable(mem_dq_o)));
  // R5
  no_drive_with_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_no);
  // R5
  turn_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> $past(mem_oe_no));
endmodule

// File: tb/sram_ctrl_test.sv
`timescale 1ns/1ps
module sram_ctrl_test;
  localparam int GRADE  = 0;
  localparam int CLK_NS = 8;

  // memory minima from R7, in ns
  localparam int AA_NS   = GRADE == 0 ? 55 : 70;
  localparam int CYC_NS  = GRADE == 0 ? 55 : 70;
  localparam int OE_NS   = GRADE == 0 ? 25 : 30;
  localparam int WP_NS   = GRADE == 0 ? 30 : 35;
  localparam int AW_NS   = GRADE == 0 ? 40 : 50;
  localparam int DW_NS   = GRADE == 0 ? 25 : 30;
  localparam int REL_NS  = GRADE == 0 ? 30 : 35;
  localparam int EXP_AA  = (AA_NS + CLK_NS - 1) / CLK_NS;
  localparam int EXP_CYC = (CYC_NS + CLK_NS - 1) / CLK_NS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, req_we = 1'b0;
  logic [20:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        ready_o, rvalid_o;
  logic [7:0]  rdata_o;
  logic [20:0] mem_addr_o;
  logic        mem_ce1_no, mem_ce2_o, mem_we_no, mem_oe_no, mem_dq_oe_o;
  logic [7:0]  mem_dq_o;
  logic [7:0]  mem_dq_i = '0;

  int checks = 0, fails = 0, cyc = 0, writes_issued = 0, model_writes = 0;
  logic [7:0] shadow [int];
  logic [7:0] mem_arr [int];
  logic [7:0] exp_q [$];
  int         acc_q [$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sram_ctrl #(.CLK_NS(CLK_NS), .SPEED_GRADE(GRADE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .ready_o, .rvalid_o,
    .rdata_o, .mem_addr_o, .mem_ce1_no, .mem_ce2_o, .mem_we_no, .mem_oe_no,
    .mem_dq_o, .mem_dq_i, .mem_dq_oe_o);

  task automatic check(input bit ok, input string req_tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req_tag, what, act, exp);
    end
  endtask

  task automatic check_idle(input string what);
    check(mem_ce1_no && !mem_ce2_o && mem_we_no && mem_oe_no && !mem_dq_oe_o,
          "R1", what, {mem_ce1_no, mem_ce2_o, mem_we_no, mem_oe_no, mem_dq_oe_o},
          5'b10110);
  endtask

  // behavioural memory: polled half a cycle step away from clock edges
  initial begin
    real t_addr, t_wf, t_dq, t_oe, t_sel, drive_until, now;
    logic [20:0] p_addr;
    logic [7:0]  p_dq, stored;
    logic p_wr, p_dq_oe, p_sel, p_rd, p_cont;
    t_addr = 0; t_wf = 0; t_dq = 0; t_oe = 0; t_sel = 0; drive_until = -100;
    p_addr = '0; p_dq = '0; p_wr = 0; p_dq_oe = 0; p_sel = 0; p_rd = 0; p_cont = 0;
    #0.5;
    forever begin
      logic sel, wr, rd, drv, valid, cont;
      #1;
      now = $realtime;
      sel = !mem_ce1_no && mem_ce2_o;
      wr  = sel && !mem_we_no;
      rd  = sel && mem_we_no && !mem_oe_no;
      if (rst_n) begin
        if (mem_addr_o != p_addr) begin
          if (wr || p_wr) begin
            fails++; checks++;
            $display("FAIL R4 address moved during write actual=%0h expected=%0h",
                     mem_addr_o, p_addr);
          end
          t_addr = now;
        end
        if (mem_dq_o != p_dq || (mem_dq_oe_o && !p_dq_oe)) t_dq = now;
        if (sel && !p_sel) t_sel = now;
        if (wr && !p_wr) t_wf = now;
        if (!wr && p_wr) begin
          check(now - t_wf >= WP_NS, "R3", "write pulse ns", int'(now - t_wf), WP_NS);
          check(now - t_addr >= AW_NS, "R3", "addr to end ns", int'(now - t_addr), AW_NS);
          check(p_dq_oe && now - t_dq >= DW_NS, "R3", "data setup ns",
                int'(now - t_dq), DW_NS);
          check(mem_dq_oe_o, "R3", "data hold at end", mem_dq_oe_o, 1);
          mem_arr[int'(p_addr)] = p_dq;
          model_writes++;
        end
        if (rd && !p_rd) t_oe = now;
        if (rd) drive_until = now + REL_NS;
        drv = rd || (now < drive_until);
        cont = drv && mem_dq_oe_o;
        if (cont && !p_cont) begin
          fails++; checks++;
          $display("FAIL R5 bus contention actual=1 expected=0");
        end
        p_cont = cont;
        stored = mem_arr.exists(int'(mem_addr_o)) ? mem_arr[int'(mem_addr_o)] : 8'h00;
        valid = rd && (now - t_addr >= AA_NS) && (now - t_oe >= OE_NS) &&
                (now - t_sel >= AA_NS);
        mem_dq_i = valid ? stored : (drv ? ~stored : 8'h00);
      end
      p_addr = mem_addr_o; p_dq = mem_dq_o; p_wr = wr; p_dq_oe = mem_dq_oe_o;
      p_sel = sel; p_rd = rd;
    end
  end

  // monitor: scoreboard for read returns
  always @(negedge clk) begin
    if (rst_n && rvalid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9", "unexpected rvalid", 1, 0);
      end else begin
        logic [7:0] e;
        int a;
        e = exp_q.pop_front();
        a = acc_q.pop_front();
        check(rdata_o == e, "R2", "read data", rdata_o, e);
        check(cyc - a == EXP_AA, "R2 R7", "read latency cycles", cyc - a, EXP_AA);
      end
    end
  end

  // driver: called at a negedge, returns at the negedge where ready is back
  task automatic op(input logic wr, input logic [20:0] a, input logic [7:0] d,
                    input bit noise);
    int busy;
    req = 1'b1; req_we = wr; req_addr = a; req_wdata = d;
    while (!ready_o) @(negedge clk);
    if (!wr) begin
      exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00);
      acc_q.push_back(cyc + 1);
    end else begin
      shadow[int'(a)] = d;
      writes_issued++;
    end
    @(negedge clk);
    req = 1'b0;
    busy = 0;
    while (!ready_o) begin
      busy++;
      if (noise && busy == 2) begin
        req = 1'b1; req_we = 1'b1; req_addr = 21'h00777; req_wdata = 8'h3C;
      end
      @(negedge clk);
    end
    req = 1'b0;
    check(busy >= EXP_CYC, "R6", "ready low cycles", busy, EXP_CYC);
    check_idle("idle after op");
  endtask

  initial begin : watchdog
    #(CLK_NS * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("during reset");
    check(ready_o, "R1", "ready in reset", ready_o, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("after reset");
    // R3 R4 writes at edge addresses and mixed patterns
    op(1'b1, 21'h000000, 8'h5A, 1'b0);
    op(1'b1, 21'h1FFFFF, 8'hA5, 1'b0);
    op(1'b1, 21'h012345, 8'hFF, 1'b0);
    op(1'b1, 21'h000777, 8'hC3, 1'b0);
    op(1'b1, 21'h0AAAAA, 8'h81, 1'b0);
    // R2 back-to-back reads
    op(1'b0, 21'h1FFFFF, 8'h00, 1'b0);
    op(1'b0, 21'h000000, 8'h00, 1'b0);
    op(1'b0, 21'h0AAAAA, 8'h00, 1'b0);
    op(1'b0, 21'h012345, 8'h00, 1'b0);
    // R8 write then read at once
    op(1'b1, 21'h054321, 8'h7E, 1'b0);
    op(1'b0, 21'h054321, 8'h00, 1'b0);
    // R8 R5 read then write at once, then read back
    op(1'b0, 21'h000000, 8'h00, 1'b0);
    op(1'b1, 21'h000000, 8'h11, 1'b0);
    op(1'b0, 21'h000000, 8'h00, 1'b0);
    // R6 request during a busy read must be ignored
    op(1'b0, 21'h012345, 8'h00, 1'b1);
    op(1'b0, 21'h000777, 8'h00, 1'b0);
    repeat (12) @(negedge clk);
    check(exp_q.size() == 0, "R9", "reads pending", exp_q.size(), 0);
    check(model_writes == writes_issued, "R6", "writes seen by memory",
          model_writes, writes_issued);
    check(!rvalid_o, "R9", "rvalid idle", rvalid_o, 0);
    check_idle("final");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule